// File: doc/BRIEF.md
# Descriptor Condition Decision Unit

This block is the decision stage of a descriptor-driven DMA channel. Each descriptor carries three small policy fields in its command word: interrupt, wait and branch. When the channel finishes with a descriptor it pulses an evaluate strobe. The unit then resolves each policy against a 4-bit device status. The compare behind each decision is masked and programmable, and each decision has its own select register.

There are three results. The interrupt request is a sticky level that holds until software clears it. The wait flag tells the sequencer to stall. The branch-taken flag, together with the next descriptor pointer, tells it where to fetch next: the branch target when the branch is taken, and the sequential next descriptor when it is not.

Descriptor fetch, memory traffic and register access are outside this block. Their values arrive on plain input ports.

Top module: `desc_cond_unit`

## Requirements
- R1: While reset is asserted and after its release, irq_o, wait_o and branch_o are 0 and next_ptr_o is 0 until the first evaluate strobe.
- R2: The condition for a decision is true when (dev_stat_i AND mask) equals (value AND mask). The mask is bits 19:16 and the value is bits 3:0 of that decision's select register; all other select bits have no effect.
- R3: Policy code 0 (never) yields false and code 3 (always) yields true for every device status and select value.
- R4: Policy code 1 yields the condition and policy code 2 yields its inverse.
- R5: In cmd_i the interrupt policy is bits 5:4, the branch policy bits 3:2 and the wait policy bits 1:0. Interrupt uses intr_sel_i, wait uses wait_sel_i and branch uses br_sel_i; cmd_i bits 15:6 have no effect.
- R6: wait_o and branch_o take the decision result on the clock edge where eval_i is high, and they hold their value on every other edge.
- R7: irq_o is set on an edge where eval_i is high and the interrupt decision is true. It stays set through later evaluations whose decision is false, until it is cleared.
- R8: irq_o is cleared by irq_clear_i on an edge with no qualifying interrupt evaluation; when both occur on the same edge, irq_o is set.
- R9: On an evaluate edge, next_ptr_o becomes br_target_i if the branch is taken, else cur_ptr_i + 16.
- R10: next_ptr_o holds its value on edges without eval_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_i | input | 1 | Single-cycle evaluate strobe |
| cmd_i | input | 16 | Descriptor command word holding the three policy fields |
| dev_stat_i | input | 4 | Channel device status nibble |
| intr_sel_i | input | 32 | Interrupt select: mask 19:16, value 3:0 |
| wait_sel_i | input | 32 | Wait select: mask 19:16, value 3:0 |
| br_sel_i | input | 32 | Branch select: mask 19:16, value 3:0 |
| cur_ptr_i | input | 32 | Address of the current descriptor |
| br_target_i | input | 32 | Branch target address from the descriptor |
| irq_clear_i | input | 1 | Software clear of the interrupt request |
| irq_o | output | 1 | Sticky interrupt request |
| wait_o | output | 1 | Wait decision |
| branch_o | output | 1 | Branch-taken decision |
| next_ptr_o | output | 32 | Next descriptor address |

## Verification
The bench drives select registers whose bits outside the mask and value fields are filled with noise. A design that decoded the wrong slice would then decide on those bits.

It also crosses the policy fields against one another. Swapping two fields, or feeding one decision from another decision's select register, would then show up as a wrong wait or branch flag.

For the interrupt, the bench hits a clear and a qualifying evaluation on the same edge, and it checks that a failing evaluation leaves a pending request in place. A non-sticky or clear-priority design loses the request in either case.

It also checks that idle edges with changing inputs leave every output alone, and that the not-taken pointer steps by exactly one descriptor.

// File: rtl/dcu_pkg.sv
package dcu_pkg;
  localparam int STAT_W     = 4;
  localparam int SEL_W      = 32;
  localparam int MASK_LSB   = 16;
  localparam int POL_W      = 2;
  localparam int CMD_W      = 16;
  localparam int ADDR_W     = 32;
  localparam int DESC_BYTES = 16;
  localparam int N_LANES    = 3;

  typedef enum logic [POL_W-1:0] {
    POL_NEVER  = 2'd0,
    POL_IF_HIT = 2'd1,
    POL_IF_MISS= 2'd2,
    POL_ALWAYS = 2'd3
  } policy_e;

  // lane order: 0 interrupt, 1 wait, 2 branch
  localparam int LANE_INTR = 0;
  localparam int LANE_WAIT = 1;
  localparam int LANE_BR   = 2;

  function automatic int lane_field_lsb(input int lane);
    case (lane)
      LANE_INTR: return 4;
      LANE_BR:   return 2;
      default:   return 0;
    endcase
  endfunction

  function automatic logic masked_hit(input logic [STAT_W-1:0] stat,
                                      input logic [STAT_W-1:0] mask,
                                      input logic [STAT_W-1:0] value);
    return ((stat & mask) == (value & mask));
  endfunction

  function automatic logic apply_policy(input policy_e pol, input logic hit);
    case (pol)
      POL_NEVER:   return 1'b0;
      POL_IF_HIT:  return hit;
      POL_IF_MISS: return ~hit;
      default:     return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/dcu_sel_match.sv
module dcu_sel_match
  import dcu_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] value_i,
  output logic         hit_o
);
  assign hit_o = masked_hit(stat_i, mask_i, value_i);
endmodule

// File: rtl/dcu_policy.sv
module dcu_policy
  import dcu_pkg::*;
(
  input  logic [POL_W-1:0] pol_i,
  input  logic             hit_i,
  output logic             fire_o
);
  policy_e pol;
  assign pol    = policy_e'(pol_i);
  assign fire_o = apply_policy(pol, hit_i);
endmodule

// File: rtl/dcu_next_ptr.sv
module dcu_next_ptr
  import dcu_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int STEP = DESC_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eval_i,
  input  logic          take_i,
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] next_o
);
  logic [AW-1:0] seq_addr;
  assign seq_addr = cur_i + AW'(STEP);

  always_ff @(posedge clk) begin
    if (!rst_n)      next_o <= '0;
    else if (eval_i) next_o <= take_i ? target_i : seq_addr;
  end

  // R9
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i && !take_i |=> next_o == $past(cur_i) + AW'(STEP));
  // R10
  next_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> $stable(next_o));
endmodule

// File: rtl/desc_cond_unit.sv
module desc_cond_unit
  import dcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [STAT_W-1:0] dev_stat_i,
  input  logic [SEL_W-1:0]  intr_sel_i,
  input  logic [SEL_W-1:0]  wait_sel_i,
  input  logic [SEL_W-1:0]  br_sel_i,
  input  logic [ADDR_W-1:0] cur_ptr_i,
  input  logic [ADDR_W-1:0] br_target_i,
  input  logic              irq_clear_i,
  output logic              irq_o,
  output logic              wait_o,
  output logic              branch_o,
  output logic [ADDR_W-1:0] next_ptr_o
);
  logic [SEL_W-1:0] sel_arr [N_LANES];
  logic [N_LANES-1:0] lane_hit;
  logic [N_LANES-1:0] lane_fire;
  logic [POL_W-1:0]   lane_pol [N_LANES];

  assign sel_arr[LANE_INTR] = intr_sel_i;
  assign sel_arr[LANE_WAIT] = wait_sel_i;
  assign sel_arr[LANE_BR]   = br_sel_i;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam int FLSB = lane_field_lsb(g);
    assign lane_pol[g] = cmd_i[FLSB +: POL_W];
    dcu_sel_match #(.W(STAT_W)) u_match (
      .stat_i (dev_stat_i),
      .mask_i (sel_arr[g][MASK_LSB +: STAT_W]),
      .value_i(sel_arr[g][0 +: STAT_W]),
      .hit_o  (lane_hit[g])
    );
    dcu_policy u_pol (
      .pol_i (lane_pol[g]),
      .hit_i (lane_hit[g]),
      .fire_o(lane_fire[g])
    );
  end

  // named events for checking
  logic irq_set_ev, irq_clr_ev;
  assign irq_set_ev = eval_i & lane_fire[LANE_INTR];
  assign irq_clr_ev = irq_clear_i & ~irq_set_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o    <= 1'b0;
      wait_o   <= 1'b0;
      branch_o <= 1'b0;
    end else begin
      if (irq_set_ev)      irq_o <= 1'b1;
      else if (irq_clr_ev) irq_o <= 1'b0;
      if (eval_i) begin
        wait_o   <= lane_fire[LANE_WAIT];
        branch_o <= lane_fire[LANE_BR];
      end
    end
  end

  dcu_next_ptr #(.AW(ADDR_W), .STEP(DESC_BYTES)) u_next (
    .clk     (clk),
    .rst_n   (rst_n),
    .eval_i  (eval_i),
    .take_i  (lane_fire[LANE_BR]),
    .cur_i   (cur_ptr_i),
    .target_i(br_target_i),
    .next_o  (next_ptr_o)
  );

  logic unused_bits;
  assign unused_bits = ^{cmd_i[CMD_W-1:6], intr_sel_i[SEL_W-1:MASK_LSB+STAT_W],
                         intr_sel_i[MASK_LSB-1:STAT_W], wait_sel_i[SEL_W-1:MASK_LSB+STAT_W],
                         wait_sel_i[MASK_LSB-1:STAT_W], br_sel_i[SEL_W-1:MASK_LSB+STAT_W],
                         br_sel_i[MASK_LSB-1:STAT_W]};

  // R6
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> $stable(wait_o) && $stable(branch_o));
  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !irq_clear_i |=> irq_o);
  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr_ev |=> !irq_o);
  // R3
  never_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i && cmd_i[3:2] == 2'd0 |=> !branch_o);
  // R3
  always_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i && cmd_i[1:0] == 2'd3 |=> wait_o);
endmodule

// File: tb/sim_desc_cond_unit.sv
module sim_desc_cond_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eval_i = 1'b0;
  logic [15:0] cmd_i = '0;
  logic [3:0]  dev_stat_i = '0;
  logic [31:0] intr_sel_i = '0, wait_sel_i = '0, br_sel_i = '0;
  logic [31:0] cur_ptr_i = '0, br_target_i = '0;
  logic irq_clear_i = 1'b0;
  logic irq_o, wait_o, branch_o;
  logic [31:0] next_ptr_o;

  int checks = 0;
  int errors = 0;
  logic m_irq = 0, m_wait = 0, m_br = 0;
  logic [31:0] m_next = 0;

  always #10 clk = ~clk;

  desc_cond_unit u0 (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .cmd_i(cmd_i),
    .dev_stat_i(dev_stat_i), .intr_sel_i(intr_sel_i), .wait_sel_i(wait_sel_i),
    .br_sel_i(br_sel_i), .cur_ptr_i(cur_ptr_i), .br_target_i(br_target_i),
    .irq_clear_i(irq_clear_i), .irq_o(irq_o), .wait_o(wait_o),
    .branch_o(branch_o), .next_ptr_o(next_ptr_o)
  );

  function automatic bit ref_cond(input logic [3:0] st, input logic [31:0] sel);
    bit ok = 1;
    for (int b = 0; b < 4; b++)
      if (sel[16+b] && (st[b] != sel[b])) ok = 0;
    return ok;
  endfunction

  function automatic bit ref_dec(input logic [1:0] code, input bit c);
    if (code == 2'd0) return 0;
    if (code == 2'd3) return 1;
    if (code == 2'd1) return c;
    return !c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit ev, input bit clr, input string tag);
    bit fi, fw, fb;
    @(negedge clk);
    eval_i = ev; irq_clear_i = clr;
    fi = ref_dec(cmd_i[5:4], ref_cond(dev_stat_i, intr_sel_i));
    fw = ref_dec(cmd_i[1:0], ref_cond(dev_stat_i, wait_sel_i));
    fb = ref_dec(cmd_i[3:2], ref_cond(dev_stat_i, br_sel_i));
    if (ev) begin
      m_wait = fw; m_br = fb;
      m_next = fb ? br_target_i : cur_ptr_i + 32'd16;
    end
    if (ev && fi) m_irq = 1;
    else if (clr) m_irq = 0;
    @(posedge clk); #2;
    chk({tag, " irq"}, {31'd0, irq_o}, {31'd0, m_irq});
    chk({tag, " wait"}, {31'd0, wait_o}, {31'd0, m_wait});
    chk({tag, " branch"}, {31'd0, branch_o}, {31'd0, m_br});
    chk({tag, " next"}, next_ptr_o, m_next);
    eval_i = 0; irq_clear_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #2;
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 wait", {31'd0, wait_o}, 0);
    chk("R1 branch", {31'd0, branch_o}, 0);
    chk("R1 next", next_ptr_o, 0);
    @(negedge clk); rst_n = 1;
    step(0, 0, "R1 after release");

    // R3: never / always across every status
    for (int s = 0; s < 16; s++) begin
      dev_stat_i = 4'(s);
      intr_sel_i = 32'h000F_0000 | 32'(s ^ 1);
      wait_sel_i = 32'h000F_0000 | 32'(s);
      br_sel_i   = 32'h000F_0000 | 32'(s);
      cmd_i = 16'h0003; cur_ptr_i = 32'h100 + 32'(s * 16); br_target_i = 32'hABC0;
      step(1, 0, "R3 never/always");
      cmd_i = 16'h0030 | 16'h000C;
      step(1, 1, "R3 always irq/branch");
    end

    // R4: if-hit vs if-miss with matching and non-matching status
    cmd_i = 16'h0016; dev_stat_i = 4'b1010;
    intr_sel_i = 32'h000C_0008; wait_sel_i = 32'h0003_0001; br_sel_i = 32'h0006_0002;
    step(1, 1, "R4 hit/miss");
    cmd_i = 16'h0029; step(1, 1, "R4 swapped codes");

    // R2: noise outside mask/value fields
    cmd_i = 16'h0015; dev_stat_i = 4'b1101;
    intr_sel_i = 32'hA5A3_C7A5; wait_sel_i = 32'h5A50_FFF0; br_sel_i = 32'hFFF8_0007;
    step(1, 1, "R2 noisy selects");
    dev_stat_i = 4'b0010; step(1, 1, "R2 noisy selects miss");

    // R5: upper command bits ignored, fields distinct
    cmd_i = 16'hFFC4; dev_stat_i = 4'h0;
    intr_sel_i = 32'h000F_000F; wait_sel_i = 32'h0; br_sel_i = 32'h0;
    step(1, 1, "R5 field map");

    // R7: sticky irq survives failing evaluation
    cmd_i = 16'h0030; step(1, 0, "R7 set");
    cmd_i = 16'h0000; step(1, 0, "R7 hold on no-fire eval");
    step(0, 0, "R7 hold idle");
    // R8: clear, then simultaneous set and clear
    step(0, 1, "R8 clear");
    cmd_i = 16'h0030; step(1, 1, "R8 set wins");

    // R6 and R10: idle edges with churning inputs
    for (int k = 0; k < 8; k++) begin
      cmd_i = 16'($urandom); dev_stat_i = 4'($urandom);
      wait_sel_i = $urandom; br_sel_i = $urandom; cur_ptr_i = $urandom; br_target_i = $urandom;
      step(0, 0, "R6 R10 hold");
    end

    // R9 and everything: random mix
    for (int k = 0; k < 600; k++) begin
      cmd_i = 16'($urandom); dev_stat_i = 4'($urandom);
      intr_sel_i = $urandom; wait_sel_i = $urandom; br_sel_i = $urandom;
      cur_ptr_i = $urandom & 32'hFFFF_FFF0; br_target_i = $urandom;
      step(($urandom % 3) != 0, ($urandom % 4) == 0, "R9 R5 R7 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule